// File: doc/BRIEF.md
# One-Shot Countdown Timer

A private countdown timer for one processor core, reached through a small 32-bit register bus. Software stores a start value, sets an interrupt mask bit and a run bit, and the counter then steps down by one on every clock cycle. When it steps from one to zero it sets a sticky event flag. The interrupt line is high while that flag is set and the interrupt mask bit is set.

The timer runs once. Having reached zero it halts there until software stores a fresh start value. Software acknowledges the event by writing a one to the flag. The expected arming order is: acknowledge the flag, write the control word with only the mask bit set, store the start value, then set the run bit. Reads return data one cycle after the request.

Top module: `oneshot_timer`

## Requirements
- R1: After reset every register (start value, counter, control, flag) reads zero, the read data bus is zero and the interrupt line is low.
- R2: A write at offset 0x0 stores the start value, which reads back at 0x0, and loads the counter with it in the same cycle. A load write takes priority over a decrement in the same cycle, and it never sets the flag.
- R3: The control word is at offset 0x8. Bit 0 is the run bit and bit 2 is the interrupt mask bit. Only these two bits are stored; all other bits read zero.
- R4: While the run bit is set and the counter is nonzero, the counter drops by exactly one per clock cycle. While the run bit is clear, the counter holds its value.
- R5: On reaching zero the counter stays at zero, with no reload, until the next write at offset 0x0.
- R6: The flag (offset 0xC, bit 0) is set in the cycle the counter steps from one to zero while running. It stays set until software clears it.
- R7: Writing a one to flag bit 0 clears the flag. Writing a zero to it leaves the flag unchanged.
- R8: If a clearing write to the flag coincides with a step to zero, the flag ends up set.
- R9: The interrupt line is a level equal to the flag AND the interrupt mask bit.
- R10: A read request at a given cycle returns its data on the read bus one cycle later. Offset 0x4 returns the live counter value. Cycles without a read request return zero. Writes at offset 0x4 are ignored.
- R11: The arming order (clear flag, mask-only control write, start value write, run bit write) produces a countdown from the stored value, and the flag is set exactly that many cycles after the run bit is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one cycle after a read request |
| irq_o | output | 1 | Level interrupt line |

## Verification
The bound checker watches every cycle for the following: a running, nonzero counter dropping by exactly one, a halted or zero counter holding still, the flag staying set without a clearing write, the flag being set by a step to zero, the interrupt staying low while masked, and the read bus being zero after idle cycles. Some behaviours are visible only through the bench's scenarios. These are the values software actually reads back, the masking of unused control bits, the set-over-clear collision taken through the bus, and the full arming order with its exact interrupt timing. The bench compares each of these against a cycle model that it runs beside a seeded random mix of bus traffic.

// File: rtl/oneshot_timer_pkg.sv
package oneshot_timer_pkg;
  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_STAT  = 2'd3
  } reg_idx_e;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_IEN_BIT = 2;
  localparam int unsigned STAT_EVT_BIT = 0;
  localparam int unsigned RST_SYNC_STAGES = 2;
endpackage

// File: rtl/ost_regs.sv
module ost_regs #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_load,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_q,
  output logic              run_en,
  output logic              irq_en
);
  import oneshot_timer_pkg::*;

  logic [DATA_W-1:0] load_d;
  logic              run_d, ien_d;

  always_comb begin
    load_d = load_q;
    run_d  = run_en;
    ien_d  = irq_en;
    if (wr_load) load_d = wdata;
    if (wr_ctrl) begin
      run_d = wdata[CTRL_RUN_BIT];
      ien_d = wdata[CTRL_IEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      run_en <= 1'b0;
      irq_en <= 1'b0;
    end else begin
      if (wr_load) load_q <= load_d;
      if (wr_ctrl) begin
        run_en <= run_d;
        irq_en <= ien_d;
      end
    end
  end
endmodule

// File: rtl/ost_counter.sv
module ost_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_stb,
  input  logic [DATA_W-1:0] load_val,
  input  logic              run_en,
  output logic [DATA_W-1:0] count_q,
  output logic              hit_zero
);
  logic [DATA_W-1:0] count_d;
  logic              is_zero, is_one, step;

  assign is_zero  = (count_q == '0);
  assign is_one   = (count_q == DATA_W'(1));
  assign step     = run_en && !is_zero && !load_stb;
  assign hit_zero = step && is_one;

  always_comb begin
    count_d = count_q;
    if (load_stb)  count_d = load_val;
    else if (step) count_d = count_q - DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count_q <= '0;
    else if (load_stb || step) count_q <= count_d;
  end
endmodule

// File: rtl/ost_event.sv
module ost_event (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic evt_q
);
  logic evt_d;

  always_comb begin
    evt_d = evt_q;
    if (clr_i) evt_d = 1'b0;
    if (set_i) evt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  import oneshot_timer_pkg::*;

  logic [RST_SYNC_STAGES-1:0] rst_pipe;
  logic                       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_SYNC_STAGES-1];

  reg_idx_e idx;
  logic     wr_load, wr_ctrl, wr_stat, rd_req;
  assign idx     = reg_idx_e'(bus_addr[3:2]);
  assign wr_load = bus_sel && bus_wr && (idx == REG_LOAD);
  assign wr_ctrl = bus_sel && bus_wr && (idx == REG_CTRL);
  assign wr_stat = bus_sel && bus_wr && (idx == REG_STAT);
  assign rd_req  = bus_sel && !bus_wr;

  logic [DATA_W-1:0] load_q, cnt_q;
  logic              run_en, irq_en, hit_zero, evt_q;

  ost_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_load(wr_load), .wr_ctrl(wr_ctrl),
    .wdata(bus_wdata), .load_q(load_q), .run_en(run_en), .irq_en(irq_en)
  );

  ost_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .load_stb(wr_load), .load_val(bus_wdata),
    .run_en(run_en), .count_q(cnt_q), .hit_zero(hit_zero)
  );

  ost_event u_evt (
    .clk(clk), .rst_n(rst_sync_n), .set_i(hit_zero),
    .clr_i(wr_stat && bus_wdata[STAT_EVT_BIT]), .evt_q(evt_q)
  );

  logic [DATA_W-1:0] rd_mux, rdata_d;

  always_comb begin
    rd_mux = '0;
    unique case (idx)
      REG_LOAD:  rd_mux = load_q;
      REG_COUNT: rd_mux = cnt_q;
      REG_CTRL: begin
        rd_mux[CTRL_RUN_BIT] = run_en;
        rd_mux[CTRL_IEN_BIT] = irq_en;
      end
      REG_STAT:  rd_mux[STAT_EVT_BIT] = evt_q;
      default:   rd_mux = '0;
    endcase
    rdata_d = rd_req ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bus_rdata <= '0;
    else             bus_rdata <= rdata_d;
  end

  assign irq_o = evt_q && irq_en;
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] count,
  input logic              evt,
  input logic              run_en,
  input logic              irq_en,
  input logic              irq_o
);
  logic ld_wr, clr_wr, rd_req;
  assign ld_wr  = bus_sel && bus_wr && (bus_addr[3:2] == 2'd0);
  assign clr_wr = bus_sel && bus_wr && (bus_addr[3:2] == 2'd3) && bus_wdata[0];
  assign rd_req = bus_sel && !bus_wr;

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && count != '0 && !ld_wr) |=> (count == $past(count) - DATA_W'(1)));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !ld_wr) |=> $stable(count));

  // R5
  zero_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !ld_wr) |=> (count == '0));

  // R6
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && count == DATA_W'(1) && !ld_wr) |=> evt);

  // R6
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !clr_wr) |=> evt);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_o);

  // R10
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (bus_rdata == '0));
endmodule

bind oneshot_timer oneshot_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .count(cnt_q), .evt(evt_q), .run_en(run_en), .irq_en(irq_en), .irq_o(irq_o)
);

// File: tb/test_oneshot_timer.sv
module test_oneshot_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  oneshot_timer i_oneshot_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  // Reference state derived from the requirements
  logic [31:0] m_load, m_cnt, m_rdata, last_rd;
  logic        m_run, m_ien, m_evt;
  string       m_tag;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] a);
    case (a[3:2])
      2'd0: return "R2";
      2'd1: return "R10";
      2'd2: return "R3";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input logic s, input logic w, input logic [3:0] a, input logic [31:0] d);
    logic [31:0] mux, nrd, ncnt;
    logic ld, hit, nevt;
    @(negedge clk);
    last_rd = bus_rdata;
    chk(bus_rdata, m_rdata, m_tag);
    chk({31'd0, irq_o}, {31'd0, m_evt & m_ien}, "R9");
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    case (a[3:2])
      2'd0: mux = m_load;
      2'd1: mux = m_cnt;
      2'd2: mux = {29'd0, m_ien, 1'b0, m_run};
      default: mux = {31'd0, m_evt};
    endcase
    nrd  = (s && !w) ? mux : 32'd0;
    ld   = s && w && a[3:2] == 2'd0;
    hit  = m_run && !ld && m_cnt == 32'd1;
    ncnt = ld ? d : ((m_run && m_cnt != 0) ? m_cnt - 1 : m_cnt);
    nevt = hit ? 1'b1 : ((s && w && a[3:2] == 2'd3 && d[0]) ? 1'b0 : m_evt);
    if (ld) m_load = d;
    if (s && w && a[3:2] == 2'd2) begin m_run = d[0]; m_ien = d[2]; end
    m_cnt = ncnt; m_evt = nevt; m_rdata = nrd;
    m_tag = (s && !w) ? tag_of(a) : "R10";
  endtask

  task automatic idle(); step(0, 0, 4'h0, 32'd0); endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d); step(1, 1, a, d); endtask
  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    step(1, 0, a, 32'd0); idle(); v = last_rd;
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    m_load = 0; m_cnt = 0; m_rdata = 0; m_run = 0; m_ien = 0; m_evt = 0; m_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({31'd0, irq_o}, 32'd0, "R1");
    chk(bus_rdata, 32'd0, "R1");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1: every register reads zero after reset
    rd(4'h0, v); chk(v, 32'd0, "R1");
    rd(4'h4, v); chk(v, 32'd0, "R1");
    rd(4'h8, v); chk(v, 32'd0, "R1");
    rd(4'hC, v); chk(v, 32'd0, "R1");

    // R3: unused control bits read zero
    wr(4'h8, 32'hFFFF_FFFA); rd(4'h8, v); chk(v, 32'h0000_0000, "R3");
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, v); chk(v, 32'h0000_0005, "R3");
    wr(4'h8, 32'd0);

    // R11: arming order; flag rises exactly N cycles after run write
    wr(4'hC, 32'd1);
    wr(4'h8, 32'd4);
    wr(4'h0, 32'd6);
    rd(4'h0, v); chk(v, 32'd6, "R2");
    wr(4'h8, 32'd5);
    repeat (5) idle();
    chk({31'd0, irq_o}, 32'd0, "R11");
    idle();
    @(negedge clk); chk({31'd0, irq_o}, 32'd1, "R11");
    // R5: stays at zero, no reload
    repeat (4) idle();
    rd(4'h4, v); chk(v, 32'd0, "R5");
    // R7: writing zero leaves flag; writing one clears
    wr(4'hC, 32'hFFFF_FFFE); rd(4'hC, v); chk(v, 32'd1, "R7");
    wr(4'hC, 32'd1); rd(4'hC, v); chk(v, 32'd0, "R7");
    // R10: write to counter offset ignored
    wr(4'h4, 32'd99); rd(4'h4, v); chk(v, 32'd0, "R10");

    // R8: clear coincides with step to zero
    wr(4'h8, 32'd0);
    wr(4'h0, 32'd3);
    wr(4'h8, 32'd5);
    idle(); idle();
    wr(4'hC, 32'd1);
    rd(4'hC, v); chk(v, 32'd1, "R8");

    // R4: halted counter holds
    wr(4'h8, 32'd0);
    wr(4'h0, 32'd20);
    wr(4'h8, 32'd1);
    repeat (3) idle();
    wr(4'h8, 32'd0);
    rd(4'h4, v); chk(v, 32'd16, "R4");
    repeat (3) idle();
    rd(4'h4, v); chk(v, 32'd16, "R4");

    // Seeded random mix against the reference state
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom_range(0, 99);
      logic [3:0] a = {$urandom_range(0, 3) == 0 ? 2'd0 : 2'($urandom_range(0, 3)), 2'b00};
      if (r < 40) idle();
      else if (r < 70) step(1, 0, a, 32'd0);
      else if (r < 80) wr(4'h0, 32'($urandom_range(0, 12)));
      else if (r < 90) wr(4'h8, $urandom);
      else if (r < 97) wr(4'hC, 32'($urandom_range(0, 1)));
      else wr(4'h4, $urandom);
    end
    idle(); idle();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule